// File: doc/BRIEF.md
# Temperature-Aware Refresh Scheduler

This block paces the periodic auto-refresh traffic of a DRAM controller. A down-counter runs on the controller clock and expires once per refresh interval. Every expiry adds one owed refresh to a small postponement counter. The block asks the command arbiter for a refresh slot whenever anything is owed. The arbiter answers with a one-cycle grant, and it grants only once every bank has been precharged. The block never issues a DRAM command itself.

The DRAM needs 8192 refreshes per retention window, and that window shrinks as the case heats up. A 2-bit band code therefore selects one of three intervals, each half of the one before. With the default 20 ns clock the intervals are 390, 195 and 97 cycles, which matches 7.8 µs, 3.9 µs and 1.95 µs.

A move to a cooler band waits for the next reload. A move to a hotter band also shortens the interval already in progress. If the arbiter falls behind by the full allowance of postponed refreshes, an urgent flag tells it to stop deferring.

Top module: `tref_scheduler`

## Requirements
- R1: After reset, req and urgent are low, the interval timer is loaded for the coolest band, and the first expiry comes BASE cycles after enable first goes high. BASE is BASE_INTERVAL_NS / CLK_PERIOD_NS, which is 390 with the defaults.
- R2: With temp_code = 2'b00 (case up to 85 °C), expiries are exactly BASE enabled cycles apart.
- R3: temp_code = 2'b01 (85 to 95 °C) gives an interval of BASE/2 cycles (195). Both temp_code = 2'b10 (95 to 105 °C) and 2'b11 give BASE/4 cycles (97). Each division truncates to an integer.
- R4: A change to a cooler band leaves the interval in progress untouched. The new interval is used from the next reload on.
- R5: A change to a hotter band shortens the interval in progress. The timer's remaining count is clamped to at most the new band's full interval, counted from the cycle in which the new code is sampled. For example, a hot code sampled 11 cycles into a cool interval produces the next expiry 11 + 97 = 108 cycles after the previous one.
- R6: Each expiry adds one postponed refresh. req is high in every cycle in which the postponed count is non-zero, and req rises in the cycle right after an expiry.
- R7: The postponed count saturates at MAX_POSTPONE (8). urgent is high exactly when the count equals 8.
- R8: A grant while req is high removes one postponed refresh. A grant while req is low is ignored and does not make the count go below zero. A grant and an expiry in the same cycle leave the count unchanged.
- R9: While enable is low the interval timer holds its value, so the interval pauses and resumes. Grants still take postponed refreshes off the count during that time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Lets the interval timer run |
| temp_code | input | 2 | Case-temperature band: 00 cool, 01 warm, 10 and 11 hot |
| grant | input | 1 | Arbiter has issued one refresh (one-cycle pulse) |
| req | output | 1 | At least one refresh is owed |
| urgent | output | 1 | The postponement allowance is used up |

## Verification
The hardest case to reach is the saturated postponement counter, and then draining it one grant at a time without an expiry landing on a grant. To get there, the stimulus holds grant low through ten hot-band intervals. It then spaces the grants so that none of them coincides with the next expiry. Idle grants come next, placed before an expiry so that an underflow would show up as req going high early. Band changes are timed by counting cycles from a req rising edge, which makes the clamped interval length exact and lets it be checked to the cycle.

// File: rtl/tref_pkg.sv
package tref_pkg;

  typedef enum logic [1:0] {
    BAND_COOL = 2'd0,
    BAND_WARM = 2'd1,
    BAND_HOT  = 2'd2
  } band_t;

  // Map the two-bit temperature code onto a band; the spare code is hottest.
  function automatic band_t band_of(input logic [1:0] code);
    case (code)
      2'b00:   return BAND_COOL;
      2'b01:   return BAND_WARM;
      default: return BAND_HOT;
    endcase
  endfunction

  // Each hotter band halves the interval of the one below it.
  function automatic int unsigned interval_cyc(input band_t b, input int unsigned base);
    return base >> b;
  endfunction

  function automatic logic is_hotter(input band_t a, input band_t b);
    return a > b;
  endfunction

endpackage

// File: rtl/tref_band_sel.sv
module tref_band_sel
  import tref_pkg::*;
(
  input  logic [1:0] temp_code,
  input  band_t      cur_band,
  output band_t      new_band,
  output logic       hotter
);

  always_comb begin
    new_band = band_of(temp_code);
    hotter   = is_hotter(new_band, cur_band);
  end

endmodule

// File: rtl/tref_timer.sv
module tref_timer
  import tref_pkg::*;
#(
  parameter int unsigned BASE_CYC = 390,
  parameter int unsigned CNT_W    = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  band_t            new_band,
  input  logic             hotter,
  output logic             expire,
  output logic             hot_cut,
  output logic [CNT_W-1:0] cnt,
  output band_t            cur_band
);

  logic [CNT_W-1:0] reload_val;
  logic [CNT_W-1:0] cnt_dec;

  always_comb begin
    reload_val = CNT_W'(interval_cyc(new_band, BASE_CYC) - 1);
    cnt_dec    = cnt - CNT_W'(1);
    expire     = enable && (cnt == '0);
    hot_cut    = enable && (cnt != '0) && hotter;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= CNT_W'(BASE_CYC - 1);
      cur_band <= BAND_COOL;
    end else if (expire) begin
      cnt      <= reload_val;
      cur_band <= new_band;
    end else if (hot_cut) begin
      cnt      <= (cnt_dec < reload_val) ? cnt_dec : reload_val;
      cur_band <= new_band;
    end else if (enable) begin
      cnt      <= cnt_dec;
    end
  end

endmodule

// File: rtl/tref_debt.sv
module tref_debt #(
  parameter int unsigned MAX_POSTPONE = 8,
  parameter int unsigned DEBT_W       = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              expire,
  input  logic              grant,
  output logic [DEBT_W-1:0] debt,
  output logic              grant_take,
  output logic              req,
  output logic              urgent
);

  localparam logic [DEBT_W-1:0] FULL = DEBT_W'(MAX_POSTPONE);

  logic [DEBT_W-1:0] debt_nxt;

  always_comb begin
    grant_take = grant && (debt != '0);
    debt_nxt   = debt;
    if (expire && !grant_take) begin
      if (debt != FULL) debt_nxt = debt + DEBT_W'(1);
    end else if (grant_take && !expire) begin
      debt_nxt = debt - DEBT_W'(1);
    end
    req    = (debt != '0);
    urgent = (debt == FULL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) debt <= '0;
    else        debt <= debt_nxt;
  end

endmodule

// File: rtl/tref_scheduler.sv
module tref_scheduler
  import tref_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS    = 20,
  parameter int unsigned BASE_INTERVAL_NS = 7800,
  parameter int unsigned MAX_POSTPONE     = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic [1:0] temp_code,
  input  logic       grant,
  output logic       req,
  output logic       urgent
);

  localparam int unsigned BASE_CYC = BASE_INTERVAL_NS / CLK_PERIOD_NS;
  localparam int unsigned CNT_W    = $clog2(BASE_CYC);
  localparam int unsigned DEBT_W   = $clog2(MAX_POSTPONE + 1);

  // Named internal events, visible to the bound checker.
  band_t             new_band;
  band_t             cur_band;
  logic              hotter;
  logic              expire;
  logic              hot_cut;
  logic              grant_take;
  logic [CNT_W-1:0]  cnt;
  logic [DEBT_W-1:0] debt;

  tref_band_sel u_band (
    .temp_code (temp_code),
    .cur_band  (cur_band),
    .new_band  (new_band),
    .hotter    (hotter)
  );

  tref_timer #(
    .BASE_CYC (BASE_CYC),
    .CNT_W    (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .new_band (new_band),
    .hotter   (hotter),
    .expire   (expire),
    .hot_cut  (hot_cut),
    .cnt      (cnt),
    .cur_band (cur_band)
  );

  tref_debt #(
    .MAX_POSTPONE (MAX_POSTPONE),
    .DEBT_W       (DEBT_W)
  ) u_debt (
    .clk        (clk),
    .rst_n      (rst_n),
    .expire     (expire),
    .grant      (grant),
    .debt       (debt),
    .grant_take (grant_take),
    .req        (req),
    .urgent     (urgent)
  );

endmodule

// File: rtl/tref_scheduler_chk.sv
module tref_scheduler_chk #(
  parameter int unsigned BASE_CYC     = 390,
  parameter int unsigned CNT_W        = 9,
  parameter int unsigned DEBT_W       = 4,
  parameter int unsigned MAX_POSTPONE = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              grant,
  input logic              req,
  input logic              urgent,
  input logic              expire,
  input logic              hot_cut,
  input logic              grant_take,
  input logic [CNT_W-1:0]  cnt,
  input logic [1:0]        cur_band,
  input logic [DEBT_W-1:0] debt
);

  AST_URGENT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    urgent |-> req); // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (debt == DEBT_W'(MAX_POSTPONE) && expire && !grant) |=> urgent); // R7

  AST_EXPIRE_RAISES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> req); // R6

  AST_GRANT_TAKES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_take && !expire) |=> (debt == $past(debt) - DEBT_W'(1))); // R8

  AST_IDLE_GRANT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!req && grant && !expire) |=> !req); // R8

  AST_TIMER_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> $stable(cnt)); // R9

  AST_CUT_GOES_HOTTER: assert property (@(posedge clk) disable iff (!rst_n)
    hot_cut |=> (cur_band > $past(cur_band))); // R5

  AST_CNT_IN_BAND: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(cnt) < (BASE_CYC >> cur_band))); // R5

endmodule

bind tref_scheduler tref_scheduler_chk #(
  .BASE_CYC     (BASE_CYC),
  .CNT_W        (CNT_W),
  .DEBT_W       (DEBT_W),
  .MAX_POSTPONE (MAX_POSTPONE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .grant      (grant),
  .req        (req),
  .urgent     (urgent),
  .expire     (expire),
  .hot_cut    (hot_cut),
  .grant_take (grant_take),
  .cnt        (cnt),
  .cur_band   (cur_band),
  .debt       (debt)
);

// File: tb/tref_scheduler_test.sv
module tref_scheduler_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic [1:0] temp_code = 2'b00;
  logic       grant = 1'b0;
  wire        req;
  wire        urgent;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tref_scheduler uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .temp_code (temp_code),
    .grant     (grant),
    .req       (req),
    .urgent    (urgent)
  );

  // Interval per band in cycles, from the temperature windows at 20 ns.
  function automatic int band_cycles(input int b);
    int ns_per_refresh;
    ns_per_refresh = (64_000_000 >> b) / 8192;
    if (b == 2) ns_per_refresh = 1950;
    return ns_per_refresh / 20;
  endfunction

  // Behavioural reference: cycles left, band in use, refreshes owed.
  int m_left = 390;
  int m_band = 0;
  int m_owed = 0;

  always @(posedge clk) begin
    int tb_band;
    int fired;
    if (!rst_n) begin
      m_left = band_cycles(0);
      m_band = 0;
      m_owed = 0;
    end else begin
      fired = 0;
      tb_band = (temp_code == 2'b11) ? 2 : int'(temp_code);
      if (enable) begin
        if (m_left == 1) begin
          fired = 1;
          m_left = band_cycles(tb_band);
          m_band = tb_band;
        end else if (tb_band > m_band) begin
          m_left = (m_left - 1 < band_cycles(tb_band)) ? m_left - 1 : band_cycles(tb_band);
          m_band = tb_band;
        end else begin
          m_left = m_left - 1;
        end
      end
      if (grant && m_owed > 0) m_owed = m_owed - 1 + fired;
      else m_owed = m_owed + fired;
      if (m_owed > 8) m_owed = 8;
    end
  end

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", tag, actual, expected, cycles);
    end
  endtask

  // Cycle-by-cycle comparison against the model.
  always @(negedge clk) begin
    cycles++;
    check("R6 req vs model", int'(req), (m_owed > 0) ? 1 : 0);
    check("R7 urgent vs model", int'(urgent), (m_owed == 8) ? 1 : 0);
  end

  task automatic report;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
      report();
    end
  end

  // Grant every pending request until req shows a fresh rising edge.
  task automatic wait_rise;
    logic prev;
    prev = 1'b1;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      grant = req;
      if (req && !prev) break;
      prev = req;
    end
  endtask

  // Measure cycles to the next rise of req; optional code change and pause.
  task automatic gap(input int at_n, input logic [1:0] nc,
                     input int dis_from, input int dis_to, output int n);
    logic prev;
    prev = 1'b1;
    n = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      n++;
      if (n == at_n) temp_code = nc;
      if (n == dis_from) enable = 1'b0;
      if (n == dis_to) enable = 1'b1;
      grant = req;
      if (req && !prev) break;
      prev = req;
    end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check("R1 req in reset", int'(req), 0);
    check("R1 urgent in reset", int'(urgent), 0);
    rst_n = 1'b1;

    // R9: disabled timer never expires.
    repeat (50) @(negedge clk);
    check("R9 no req while disabled", int'(req), 0);

    enable = 1'b1;
    n = 0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      n++;
      if (req) break;
    end
    check("R1 first expiry after enable", n, 390);
    grant = 1'b1;

    gap(0, 2'b00, 0, 0, n);
    check("R2 cool interval", n, 390);
    gap(0, 2'b00, 0, 0, n);
    check("R2 cool interval repeat", n, 390);

    temp_code = 2'b01;
    gap(0, 2'b01, 0, 0, n);
    gap(0, 2'b01, 0, 0, n);
    check("R3 warm interval", n, 195);

    temp_code = 2'b10;
    gap(0, 2'b10, 0, 0, n);
    gap(0, 2'b10, 0, 0, n);
    check("R3 hot interval", n, 97);

    temp_code = 2'b11;
    gap(0, 2'b11, 0, 0, n);
    check("R3 spare code is hot", n, 97);

    // R4: cooler band waits for the reload.
    gap(10, 2'b00, 0, 0, n);
    check("R4 cooler change deferred", n, 97);
    gap(0, 2'b00, 0, 0, n);
    check("R4 cooler band after reload", n, 390);

    // R5: hotter code sampled 11 cycles in clamps the remainder.
    gap(10, 2'b10, 0, 0, n);
    check("R5 hotter cut interval", n, 108);

    // R9: 200 disabled cycles stretch the interval.
    gap(0, 2'b10, 5, 205, n);
    check("R9 paused interval", n, 297);

    // R6/R7/R8: postpone everything, then drain.
    n = 0;
    for (int i = 0; i < 1200; i++) begin
      @(negedge clk);
      n++;
      grant = (n >= 975 && n <= 982) || (n >= 990 && n <= 992);
      if (n == 1) check("R6 req low after grant", int'(req), 0);
      if (n == 98) check("R6 one owed", int'(req), 1);
      if (n == 775) begin
        check("R7 seven owed not urgent", int'(urgent), 0);
        check("R6 seven owed req", int'(req), 1);
      end
      if (n == 776) check("R7 urgent at eight", int'(urgent), 1);
      if (n == 970) check("R7 saturated still urgent", int'(urgent), 1);
      if (n == 976) check("R8 one grant clears urgent", int'(urgent), 0);
      if (n == 982) check("R8 one owed after seven grants", int'(req), 1);
      if (n == 983) check("R8 eighth grant empties", int'(req), 0);
      if (n == 1066) check("R8 idle grants ignored", int'(req), 0);
      if (n == 1067) check("R6 next expiry after idle grants", int'(req), 1);
    end

    // R8: grant held high across an expiry.
    grant = 1'b1;
    repeat (300) @(negedge clk);
    check("R8 grant held drains", int'(req), (m_owed > 0) ? 1 : 0);
    grant = 1'b0;
    repeat (5) @(negedge clk);

    report();
  end

endmodule